// File: doc/BRIEF.md
# Three-Pass Subranging Conversion Sequencer

This block is the digital core of a subranging converter that resolves a 12-bit code in three coarse-to-fine passes of 4 bits each. One bank of 15 comparators serves every pass. For each pass the block drives a segment base code and a pass index to an external resistor-ladder DAC. It waits a programmable settling time, samples the 15-bit thermometer word from the comparators, and reduces that word to a 4-bit digit. It then narrows the segment for the next pass.

After the third pass the three digits are joined, most significant first, into the 12-bit result. The result is written into the output register and announced with a one-cycle done pulse. Pass one divides full scale into 16 segments. Pass two divides the chosen segment into 16 sub-segments, which gives 1 of 256. Pass three resolves the last 4 bits inside that sub-segment, so 4096 levels are distinguished in total. A thermometer word with a hole in it is still reduced by counting its ones, and a flag records that this happened during the conversion.

Top module: `tripass_flash_seq`

## Requirements
- R1: While and after reset, `done_o`, `result_o`, `seg_sel_o`, `pass_o` and `bubble_o` are all zero.
- R2: A `start_i` seen high while idle begins a conversion. Passes 0, 1 and 2 then follow in order. Each pass lasts exactly SETTLE_CYC cycles, and `pass_o` shows the index of the current pass.
- R3: During pass k, `seg_sel_o` holds the digits already resolved, left-aligned in 12 bits with zeros below them. It is zero in pass 0 and whenever the block is idle.
- R4: Each pass digit equals the number of ones in `thermo_i` on the last settling cycle of that pass. Bit 0 is the lowest tap. The range is 0 to 15.
- R5: `result_o` = {pass-0 digit, pass-1 digit, pass-2 digit}, with bits 11:8 holding the first digit. It changes only on the edge that ends pass 2 and holds its value at all other times.
- R6: `done_o` is high for exactly one cycle. That cycle begins 3*SETTLE_CYC clock edges after the edge that accepted the start, and it is the same cycle in which the new result first appears.
- R7: `start_i` asserted during a conversion is ignored. The pass order, the timing and the result are unchanged, and no second conversion follows.
- R8: `bubble_o` is set if any sampled thermometer word has a one directly above a zero. It is cleared when a start is accepted and otherwise holds its value.
- R9: With a ladder whose tap i (0..14) in pass k sits at segment base plus (i+1)*16^(2-k) LSB, the result equals the input level for every one of the 4096 levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled when idle |
| thermo_i | input | 15 | Comparator outputs, bit 0 = lowest tap |
| seg_sel_o | output | 12 | Segment base code driven to the ladder |
| pass_o | output | 2 | Index of the current pass (0..2) |
| result_o | output | 12 | Latched conversion result |
| done_o | output | 1 | One-cycle pulse when a new result is latched |
| bubble_o | output | 1 | A non-monotonic thermometer word was seen in this conversion |

## Verification
The bench counts cycles from the edge that accepts a start. In each of the SETTLE_CYC cycles of pass k it expects `pass_o` = k, the left-aligned segment base, a low `done_o` and an unchanged `result_o`. `done_o`, the new result and the bubble flag are expected together on edge 3*SETTLE_CYC. One cycle after that, `done_o` must be low and the segment base must be back to zero. All outputs are sampled on the falling edge between active edges, so each value is read in the cycle where it is due. A behavioural ladder sweeps all 4096 levels. Forced thermometer words cover counting and bubbles, and some runs insert mid-conversion start pulses.

// File: rtl/tripass_pkg.sv
package tripass_pkg;

  // number of comparators needed to resolve the given digit width
  function automatic int cmp_count(int digit_bits);
    return (1 << digit_bits) - 1;
  endfunction

  // index width that never collapses to zero bits
  function automatic int idx_width(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/tps_thermo_decode.sv
module tps_thermo_decode
  import tripass_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [cmp_count(DIGIT_W)-1:0] thermo_i,
  output logic [DIGIT_W-1:0]            digit_o,
  output logic                          bubble_o
);

  localparam int NCMP = cmp_count(DIGIT_W);

  // population count: valid codes and bubbled codes alike
  always_comb begin
    digit_o = '0;
    for (int i = 0; i < NCMP; i++) begin
      digit_o = digit_o + DIGIT_W'(thermo_i[i]);
    end
  end

  // a hole is a set tap directly above a clear one
  logic [NCMP-2:0] hole;
  genvar g;
  generate
    for (g = 0; g < NCMP - 1; g++) begin : g_hole
      assign hole[g] = thermo_i[g+1] & ~thermo_i[g];
    end
  endgenerate

  assign bubble_o = |hole;

endmodule

// File: rtl/tps_pass_ctrl.sv
module tps_pass_ctrl
  import tripass_pkg::*;
#(
  parameter int NUM_PASSES = 3,
  parameter int SETTLE_CYC = 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start_i,
  output logic                               busy_o,
  output logic [idx_width(NUM_PASSES)-1:0]   pass_o,
  output logic                               accept_o,
  output logic                               sample_o,
  output logic                               last_o
);

  localparam int PIDX_W = idx_width(NUM_PASSES);
  localparam int CNT_W  = $clog2(SETTLE_CYC + 1);

  seq_state_e         state_q;
  logic [PIDX_W-1:0]  pass_q;
  logic [CNT_W-1:0]   cnt_q;

  assign busy_o   = (state_q == SEQ_RUN);
  assign pass_o   = pass_q;
  assign accept_o = start_i && (state_q == SEQ_IDLE);
  assign sample_o = busy_o && (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign last_o   = sample_o && (pass_q == PIDX_W'(NUM_PASSES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      pass_q  <= '0;
      cnt_q   <= '0;
    end else if (accept_o) begin
      state_q <= SEQ_RUN;
      pass_q  <= '0;
      cnt_q   <= '0;
    end else if (busy_o) begin
      if (sample_o) begin
        cnt_q <= '0;
        if (last_o) begin
          state_q <= SEQ_IDLE;
          pass_q  <= '0;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tps_assembler.sv
module tps_assembler
  import tripass_pkg::*;
#(
  parameter int PASS_BITS  = 4,
  parameter int NUM_PASSES = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              accept_i,
  input  logic                              sample_i,
  input  logic                              last_i,
  input  logic [idx_width(NUM_PASSES)-1:0]  pass_i,
  input  logic [PASS_BITS-1:0]              digit_i,
  input  logic                              bubble_i,
  output logic [PASS_BITS*NUM_PASSES-1:0]   seg_sel_o,
  output logic [PASS_BITS*NUM_PASSES-1:0]   result_o,
  output logic                              done_o,
  output logic                              bubble_o
);

  localparam int RES_W = PASS_BITS * NUM_PASSES;

  logic [RES_W-1:0] acc_q;
  logic [RES_W-1:0] placed;
  int               shamt;

  // digit of pass k lands (NUM_PASSES-1-k) digit slots above the LSB
  always_comb begin
    shamt  = PASS_BITS * (NUM_PASSES - 1 - int'(pass_i));
    placed = RES_W'(digit_i) << shamt;
  end

  assign seg_sel_o = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
      bubble_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_i) begin
        acc_q    <= '0;
        bubble_o <= 1'b0;
      end else if (sample_i) begin
        if (bubble_i) begin
          bubble_o <= 1'b1;
        end
        if (last_i) begin
          result_o <= acc_q | placed;
          acc_q    <= '0;
          done_o   <= 1'b1;
        end else begin
          acc_q <= acc_q | placed;
        end
      end
    end
  end

endmodule

// File: rtl/tripass_flash_seq.sv
module tripass_flash_seq
  import tripass_pkg::*;
#(
  parameter int PASS_BITS  = 4,
  parameter int NUM_PASSES = 3,
  parameter int SETTLE_CYC = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic [cmp_count(PASS_BITS)-1:0]   thermo_i,
  output logic [PASS_BITS*NUM_PASSES-1:0]   seg_sel_o,
  output logic [idx_width(NUM_PASSES)-1:0]  pass_o,
  output logic [PASS_BITS*NUM_PASSES-1:0]   result_o,
  output logic                              done_o,
  output logic                              bubble_o
);

  logic                 conv_busy;
  logic                 accept;
  logic                 sample;
  logic                 last;
  logic [PASS_BITS-1:0] digit;
  logic                 bubble_now;

  tps_pass_ctrl #(
    .NUM_PASSES (NUM_PASSES),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (conv_busy),
    .pass_o   (pass_o),
    .accept_o (accept),
    .sample_o (sample),
    .last_o   (last)
  );

  tps_thermo_decode #(
    .DIGIT_W (PASS_BITS)
  ) u_dec (
    .thermo_i (thermo_i),
    .digit_o  (digit),
    .bubble_o (bubble_now)
  );

  tps_assembler #(
    .PASS_BITS  (PASS_BITS),
    .NUM_PASSES (NUM_PASSES)
  ) u_asm (
    .clk       (clk),
    .rst       (rst),
    .accept_i  (accept),
    .sample_i  (sample),
    .last_i    (last),
    .pass_i    (pass_o),
    .digit_i   (digit),
    .bubble_i  (bubble_now),
    .seg_sel_o (seg_sel_o),
    .result_o  (result_o),
    .done_o    (done_o),
    .bubble_o  (bubble_o)
  );

endmodule

// File: rtl/tps_checker.sv
module tps_checker
  import tripass_pkg::*;
#(
  parameter int PASS_BITS  = 4,
  parameter int NUM_PASSES = 3
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              start_i,
  input logic                              conv_busy,
  input logic [PASS_BITS*NUM_PASSES-1:0]   seg_sel_o,
  input logic [idx_width(NUM_PASSES)-1:0]  pass_o,
  input logic [PASS_BITS*NUM_PASSES-1:0]   result_o,
  input logic                              done_o,
  input logic                              bubble_o
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6
  done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(conv_busy) && !conv_busy);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  // R2
  pass_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(pass_o) < NUM_PASSES);

  // R3
  seg_first_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!conv_busy || pass_o == '0) |-> seg_sel_o == '0);

  // R8
  bubble_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !conv_busy) |=> !bubble_o);

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && pass_o != '0) |=> (conv_busy || done_o));

endmodule

bind tripass_flash_seq tps_checker #(
  .PASS_BITS  (PASS_BITS),
  .NUM_PASSES (NUM_PASSES)
) i_tps_checker (.*);

// File: tb/test_tripass_flash_seq.sv
module test_tripass_flash_seq;

  localparam int PB = 4;
  localparam int NP = 3;
  localparam int ST = 2;
  localparam int RW = PB * NP;
  localparam int NC = (1 << PB) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NC-1:0] therm;
  logic [RW-1:0] seg;
  logic [1:0]    pidx;
  logic [RW-1:0] res;
  logic          done;
  logic          bub;

  int            vin = 0;
  logic          ovr_en = 1'b0;
  logic [NC-1:0] ovr_val = '0;
  int            errors = 0;
  int            checks = 0;

  always #4 clk = ~clk;

  // behavioural ladder and comparator bank (R9)
  function automatic logic [NC-1:0] ladder(int v, int s, int p);
    logic [NC-1:0] t;
    int step;
    step = 1 << (PB * (NP - 1 - p));
    for (int i = 0; i < NC; i++) t[i] = (v >= s + (i + 1) * step);
    return t;
  endfunction

  assign therm = ovr_en ? ovr_val : ladder(vin, int'(seg), int'(pidx));

  tripass_flash_seq #(
    .PASS_BITS  (PB),
    .NUM_PASSES (NP),
    .SETTLE_CYC (ST)
  ) i_tripass_flash_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .thermo_i  (therm),
    .seg_sel_o (seg),
    .pass_o    (pidx),
    .result_o  (res),
    .done_o    (done),
    .bubble_o  (bub)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one conversion with its expected code; poke inserts a start during pass 1
  task automatic convert(int exp, bit exp_bub, bit poke);
    int prev;
    int mask;
    prev = int'(res);
    @(negedge clk) start = 1'b1;
    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < ST; c++) begin
        @(negedge clk);
        start = poke && (p == 1) && (c == 0);
        mask  = ((1 << RW) - 1) & ~((1 << ((NP - p) * PB)) - 1);
        check(int'(pidx) == p, "R2 pass index", int'(pidx), p);
        check(int'(seg) == (exp & mask), "R3 segment base", int'(seg), exp & mask);
        check(done == 1'b0, "R6 done early", int'(done), 0);
        check(int'(res) == prev, "R5 result held", int'(res), prev);
      end
    end
    @(negedge clk) start = 1'b0;
    check(done == 1'b1, "R6 done due", int'(done), 1);
    check(int'(res) == exp, ovr_en ? "R4 digit count" : "R9 level", int'(res), exp);
    check(bub == exp_bub, "R8 bubble flag", int'(bub), int'(exp_bub));
    @(negedge clk);
    check(done == 1'b0, poke ? "R7 no restart" : "R6 single pulse", int'(done), 0);
    check(seg == '0, "R3 idle segment", int'(seg), 0);
    check(pidx == '0, "R2 idle index", int'(pidx), 0);
  endtask

  task automatic forced(logic [NC-1:0] pat);
    int c;
    c = $countones(pat);
    ovr_en  = 1'b1;
    ovr_val = pat;
    convert((c << 8) | (c << 4) | c, (pat & ~(pat >> 1) & (pat >> 1)) != '0 ? 1'b0 : 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int keep;
    repeat (5) @(negedge clk);
    check(done == 1'b0 && bub == 1'b0, "R1 reset flags", int'({done, bub}), 0);
    check(res == '0 && seg == '0 && pidx == '0, "R1 reset values", int'(res | seg), 0);
    @(negedge clk) rst = 1'b0;
    check(res == '0 && seg == '0, "R1 after reset", int'(res | seg), 0);

    // full sweep of ladder levels, with mid-conversion starts now and then
    for (int v = 0; v < (1 << RW); v++) begin
      vin = v;
      convert(v, 1'b0, (v % 97) == 5);
    end

    // result holds while idle
    keep = int'(res);
    repeat (4) @(negedge clk);
    check(int'(res) == keep, "R5 idle hold", int'(res), keep);

    // forced thermometer words: counting and bubbles
    ovr_en = 1'b1;
    ovr_val = 15'h0005;
    convert(32'h222, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check(bub == 1'b1, "R8 flag holds", int'(bub), 1);
    ovr_val = 15'h7FFF;
    convert(32'hFFF, 1'b0, 1'b0);
    ovr_val = 15'h4000;
    convert(32'h111, 1'b1, 1'b1);
    ovr_val = 15'h0000;
    convert(32'h000, 1'b0, 1'b0);
    ovr_val = 15'h00FF;
    convert(32'h888, 1'b0, 1'b0);
    ovr_val = 15'h0F0F;
    convert(32'h888, 1'b1, 1'b0);
    ovr_en = 1'b0;
    vin = 2748;
    convert(2748, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule